// File: doc/BRIEF.md
# 8-bit ALU with Masked Status Flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. One operation completes in one cycle. The caller presents an operation code, a register operand (the accumulator or an index register) and a memory operand. The block returns the 8-bit result and a write-enable for that result. It also gives the next value of the processor status byte, which it holds in its own register.

The block supports these operations:
- add with carry and subtract with inverted borrow;
- unsigned compare and the bit-test operation;
- shifts and rotates through carry;
- increment and decrement;
- AND, OR, XOR and a plain load;
- a whole-status load.

Each operation owns a fixed set of flags. Only those flags change; every other status bit keeps its value. When the decimal flag is set, add and subtract become no-ops, because decimal arithmetic is not provided.

The status register loads the next status byte on a rising clock edge when `op_valid` is high. A synchronous reset loads 0x24.

Top module: `alu8_status_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `status_q` with 0x24. In that value bit 5 (unused) and bit 2 (interrupt mask) are set and all other bits are clear. Status bit positions are: N=7, V=6, unused=5, B=4, D=3, I=2, Z=1, C=0.
- R2: `status_q` takes the value `status_next` at a rising edge only when `op_valid` is high; otherwise it holds its value. `result_we` is low whenever `op_valid` is low.
- R3: `op_code` is decoded as follows: 0 add, 1 subtract, 2 compare, 3 shift left, 4 shift right, 5 rotate left, 6 rotate right, 7 bit-test, 8 increment, 9 decrement, 10 AND, 11 OR, 12 XOR, 13 load, 14 status load, 15 no operation. In `status_next`, the status bits that an operation does not own equal `status_q`.
- R4: Add (0) with D clear gives result = (reg + mem + C) mod 256 and asserts `result_we`. C is the carry out of bit 7. V is set when both operands have the same sign and the result's sign differs. N and Z follow the result.
- R5: Subtract (1) with D clear gives result = (reg − mem − (1 − C)) mod 256 and asserts `result_we`. C is 1 when no borrow occurred. V is the signed overflow of the subtraction. N and Z follow the result.
- R6: While D (bit 3) is set, add and subtract keep `result_we` low, and `status_next` equals `status_q`.
- R7: Compare (2) keeps `result_we` low. C = (reg ≥ mem) as unsigned numbers, Z = (reg == mem), and N = bit 7 of (reg − mem) mod 256. It writes no other flag.
- R8: Shift left (3) moves reg bit 7 into C and inserts 0 at bit 0. Shift right (4) moves reg bit 0 into C and inserts 0 at bit 7. Both write the result, and N and Z follow the result.
- R9: Rotate left (5) puts the old C into bit 0 and bit 7 into C. Rotate right (6) puts the old C into bit 7 and bit 0 into C. Both write the result, and N and Z follow the result.
- R10: Bit-test (7) keeps `result_we` low. It sets Z when (reg AND mem) is zero, copies mem bit 7 into N and copies mem bit 6 into V.
- R11: Increment (8) and decrement (9) act on reg modulo 256, so 0x00 decrements to 0xFF. They write the result and change only N and Z.
- R12: AND (10), OR (11), XOR (12) of reg with mem, and load (13) of mem, write the result and change only N and Z.
- R13: Status load (14) makes `status_next` equal to mem with all eight bits replaced, and keeps `result_we` low. No operation (15) keeps `result_we` low and `status_next` equal to `status_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe; enables the result write and the status update |
| op_code | input | 4 | Operation select |
| reg_val | input | DATA_W | Register operand (accumulator or index) |
| mem_val | input | DATA_W | Memory operand |
| result | output | DATA_W | Operation result, meaningful when result_we is high |
| result_we | output | 1 | Result write-enable |
| status_next | output | 8 | Status byte after the current operation |
| status_q | output | 8 | Registered status byte |

## Verification
The properties assume that `op_code`, `reg_val` and `mem_val` are known values in every cycle after reset. The combinational checks on `status_next` and `result_we` read those inputs whether or not the strobe is high. The stimulus drives every input to a defined value from time zero and changes inputs only on falling edges. It mixes all sixteen codes, including status loads, so that the decimal flag is sometimes set and the frozen add and subtract paths are also exercised.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_CMP  = 4'd2,  OP_ASL  = 4'd3,
    OP_LSR  = 4'd4,  OP_ROL  = 4'd5,  OP_ROR  = 4'd6,  OP_BIT  = 4'd7,
    OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_AND  = 4'd10, OP_OR   = 4'd11,
    OP_XOR  = 4'd12, OP_LOAD = 4'd13, OP_PSET = 4'd14, OP_IDLE = 4'd15
  } alu_op_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_D = 3;
  localparam int FLAG_V = 6;
  localparam int FLAG_N = 7;
  localparam int STATUS_W = 8;
  localparam logic [STATUS_W-1:0] STATUS_RESET = 8'h24;

  // Flags an operation owns; decimal mode freezes add and subtract.
  function automatic logic [STATUS_W-1:0] owned_flags(alu_op_e op, logic dec);
    logic [STATUS_W-1:0] nz, m;
    nz = '0;
    nz[FLAG_N] = 1'b1;
    nz[FLAG_Z] = 1'b1;
    m  = '0;
    unique case (op)
      OP_ADD, OP_SUB: if (!dec) begin
        m = nz;
        m[FLAG_V] = 1'b1;
        m[FLAG_C] = 1'b1;
      end
      OP_CMP, OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        m = nz;
        m[FLAG_C] = 1'b1;
      end
      OP_BIT: begin
        m = nz;
        m[FLAG_V] = 1'b1;
      end
      OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_LOAD: m = nz;
      OP_PSET: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic writes_result(alu_op_e op, logic dec);
    unique case (op)
      OP_ADD, OP_SUB: return !dec;
      OP_CMP, OP_BIT, OP_PSET, OP_IDLE: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] b;
  logic         c_eff;
  logic [W:0]   sum;

  // Subtract and compare add the inverted operand; compare forces no borrow-in.
  assign b     = (op == OP_ADD) ? m : ~m;
  assign c_eff = (op == OP_CMP) ? 1'b1 : cin;
  assign sum   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c_eff};
  assign res   = sum[W-1:0];
  assign cout  = sum[W];
  assign ovf   = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
endmodule

// File: rtl/alu8_shift_logic.sv
module alu8_shift_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout
);
  localparam int MSB = W - 1;

  always_comb begin
    res  = '0;
    cout = cin;
    unique case (op)
      OP_ASL:  begin res = {a[MSB-1:0], 1'b0}; cout = a[MSB]; end
      OP_LSR:  begin res = {1'b0, a[MSB:1]};   cout = a[0];   end
      OP_ROL:  begin res = {a[MSB-1:0], cin};  cout = a[MSB]; end
      OP_ROR:  begin res = {cin, a[MSB:1]};    cout = a[0];   end
      OP_INC:  res = a + {{(W-1){1'b0}}, 1'b1};
      OP_DEC:  res = a - {{(W-1){1'b0}}, 1'b1};
      OP_AND, OP_BIT: res = a & m;
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      OP_LOAD: res = m;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flag_merge.sv
module alu8_flag_merge
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e               op,
  input  logic [W-1:0]          res,
  input  logic                  cout,
  input  logic                  ovf,
  input  logic [W-1:0]          m,
  input  logic [STATUS_W-1:0]   status_q,
  output logic [STATUS_W-1:0]   flag_mask,
  output logic [STATUS_W-1:0]   status_next
);
  localparam int MSB = W - 1;

  logic [STATUS_W-1:0] flag_val;

  always_comb begin
    flag_val         = status_q;
    flag_val[FLAG_N] = res[MSB];
    flag_val[FLAG_Z] = (res == '0);
    flag_val[FLAG_C] = cout;
    flag_val[FLAG_V] = ovf;
    if (op == OP_BIT) begin
      flag_val[FLAG_N] = m[MSB];
      flag_val[FLAG_V] = m[MSB-1];
    end
    if (op == OP_PSET) flag_val = m[STATUS_W-1:0];
  end

  assign flag_mask = owned_flags(op, status_q[FLAG_D]);

  for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
    assign status_next[i] = flag_mask[i] ? flag_val[i] : status_q[i];
  end
endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [3:0]           op_code,
  input  logic [DATA_W-1:0]    reg_val,
  input  logic [DATA_W-1:0]    mem_val,
  output logic [DATA_W-1:0]    result,
  output logic                 result_we,
  output logic [7:0]           status_next,
  output logic [7:0]           status_q
);
  alu_op_e             op;
  logic [DATA_W-1:0]   arith_res, sl_res, sel_res;
  logic                arith_c, arith_v, sl_c, sel_c, is_arith;
  logic [STATUS_W-1:0] flag_mask;

  assign op       = alu_op_e'(op_code);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);

  alu8_arith #(.W(DATA_W)) u_arith (
    .op(op), .a(reg_val), .m(mem_val), .cin(status_q[FLAG_C]),
    .res(arith_res), .cout(arith_c), .ovf(arith_v)
  );

  alu8_shift_logic #(.W(DATA_W)) u_shl (
    .op(op), .a(reg_val), .m(mem_val), .cin(status_q[FLAG_C]),
    .res(sl_res), .cout(sl_c)
  );

  assign sel_res = is_arith ? arith_res : sl_res;
  assign sel_c   = is_arith ? arith_c : sl_c;

  alu8_flag_merge #(.W(DATA_W)) u_merge (
    .op(op), .res(sel_res), .cout(sel_c), .ovf(arith_v), .m(mem_val),
    .status_q(status_q), .flag_mask(flag_mask), .status_next(status_next)
  );

  assign result    = sel_res;
  assign result_we = op_valid && writes_result(op, status_q[FLAG_D]);

  always_ff @(posedge clk) begin
    if (rst)           status_q <= STATUS_RESET;
    else if (op_valid) status_q <= status_next;
  end
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] reg_val,
  input logic [DATA_W-1:0] mem_val,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic [7:0]        status_next,
  input logic [7:0]        status_q,
  input logic [7:0]        flag_mask
);
  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> status_q == 8'h24);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> status_q == $past(status_q));

  // R3
  unowned_keep_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> ((status_q ^ $past(status_q)) & ~$past(flag_mask)) == 8'h00);

  // R4
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd0 && !status_q[3]) |->
      {status_next[0], result} == ({1'b0, reg_val} + {1'b0, mem_val} + {{DATA_W{1'b0}}, status_q[0]}));

  // R6
  decimal_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q[3] && (op_code == 4'd0 || op_code == 4'd1)) |-> (!result_we && status_next == status_q));

  // R7
  compare_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd2) |-> !result_we);

  // R10
  bit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd7) |-> (status_next[7] == mem_val[DATA_W-1] && status_next[6] == mem_val[DATA_W-2] && !result_we));

  // R13
  status_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd14) |-> (status_next == mem_val[7:0] && !result_we));
endmodule

bind alu8_status_unit alu8_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .reg_val(reg_val), .mem_val(mem_val), .result(result),
  .result_we(result_we), .status_next(status_next), .status_q(status_q),
  .flag_mask(flag_mask)
);

// File: tb/tb_alu8_status_unit.sv
module tb_alu8_status_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd15;
  logic [7:0] reg_val = 8'h00;
  logic [7:0] mem_val = 8'h00;
  logic [7:0] result, status_next, status_q;
  logic       result_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_s;

  always #5ns clk = ~clk;

  alu8_status_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .reg_val(reg_val), .mem_val(mem_val), .result(result),
    .result_we(result_we), .status_next(status_next), .status_q(status_q)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R4";   1: return "R5";   2: return "R7";
      3, 4: return "R8"; 5, 6: return "R9"; 7: return "R10";
      8, 9: return "R11"; 10, 11, 12, 13: return "R12";
      default: return "R13";
    endcase
  endfunction

  // Reference model: returns {we, result, status}.
  function automatic logic [16:0] model(input int op, input int a, input int m,
                                        input logic [7:0] s);
    int c, t, r;
    logic we, nz;
    logic [7:0] st;
    c = int'(s[0]); st = s; r = 0; we = 1'b0; nz = 1'b0;
    case (op)
      0: if (!s[3]) begin
           t = a + m + c; r = t % 256; st[0] = (t > 255);
           st[6] = (((a ^ r) & (m ^ r) & 128) != 0); nz = 1; we = 1;
         end
      1: if (!s[3]) begin
           t = a - m - (1 - c); r = (t + 512) % 256; st[0] = (t >= 0);
           st[6] = (((a ^ m) & (a ^ r) & 128) != 0); nz = 1; we = 1;
         end
      2: begin
           t = (a - m + 256) % 256; st[0] = (a >= m); st[1] = (a == m);
           st[7] = (t >= 128);
         end
      3: begin r = (a * 2) % 256; st[0] = (a >= 128); nz = 1; we = 1; end
      4: begin r = a / 2; st[0] = (a % 2 == 1); nz = 1; we = 1; end
      5: begin r = (a * 2 + c) % 256; st[0] = (a >= 128); nz = 1; we = 1; end
      6: begin r = a / 2 + c * 128; st[0] = (a % 2 == 1); nz = 1; we = 1; end
      7: begin st[1] = ((a & m) == 0); st[7] = (m >= 128); st[6] = ((m / 64) % 2 == 1); end
      8: begin r = (a + 1) % 256; nz = 1; we = 1; end
      9: begin r = (a + 255) % 256; nz = 1; we = 1; end
      10: begin r = a & m; nz = 1; we = 1; end
      11: begin r = a | m; nz = 1; we = 1; end
      12: begin r = a ^ m; nz = 1; we = 1; end
      13: begin r = m; nz = 1; we = 1; end
      14: st = m[7:0];
      default: ;
    endcase
    if (nz) begin st[7] = (r >= 128); st[1] = (r == 0); end
    return {we, r[7:0], st};
  endfunction

  task automatic do_op(input int op, input int a, input int m, input bit v);
    logic [16:0] e;
    @(negedge clk);
    op_valid = v; op_code = op[3:0]; reg_val = a[7:0]; mem_val = m[7:0];
    #1ns;
    e = model(op, a, m, exp_s);
    chk(result_we == (e[16] & v), v ? tag_of(op) : "R2", "result_we", int'(result_we), int'(e[16] & v));
    if (e[16]) chk(result == e[15:8], tag_of(op), "result", int'(result), int'(e[15:8]));
    chk(status_next == e[7:0], (op < 2 && exp_s[3]) ? "R6" : tag_of(op), "status_next",
        int'(status_next), int'(e[7:0]));
    @(posedge clk);
    #1ns;
    if (v) exp_s = e[7:0];
    chk(status_q == exp_s, v ? "R3" : "R2", "status_q", int'(status_q), int'(exp_s));
  endtask

  initial begin
    void'($urandom(32'd2024));
    exp_s = 8'h24;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(status_q == 8'h24, "R1", "reset status", int'(status_q), 32'h24);
    // Directed corners
    do_op(4, 8'hFF, 0, 1);       // R8: 0xFF >> 1 = 0x7F, C=1
    do_op(2, 1, 2, 1);           // R7: 1 vs 2 -> N=1 C=0 Z=0
    do_op(2, 8'h7F, 8'h7F, 1);   // R7 equality
    do_op(9, 0, 0, 1);           // R11 wrap to 0xFF
    do_op(8, 8'hFF, 0, 1);       // R11 wrap to 0x00
    do_op(0, 8'h7F, 1, 1);       // R4 signed overflow
    do_op(13, 0, 8'h00, 1);      // R12 load zero
    do_op(1, 5, 5, 1);           // R5 borrow in (C clear)
    do_op(5, 8'h80, 0, 1);       // R9 rotate left
    do_op(6, 8'h01, 0, 1);       // R9 rotate right with carry in
    do_op(7, 8'h0F, 8'hC0, 1);   // R10 bit-test
    do_op(11, 8'h55, 8'hAA, 0);  // R2 strobe low
    do_op(14, 0, 8'h08, 1);      // R13 set D
    do_op(0, 8'h10, 8'h20, 1);   // R6 add frozen
    do_op(1, 8'h10, 8'h20, 1);   // R6 subtract frozen
    do_op(15, 8'h33, 8'h44, 1);  // R13 no operation
    do_op(14, 0, 8'h24, 1);
    do_op(12, 8'hF0, 8'hF0, 1);  // R12 XOR to zero
    do_op(3, 8'h81, 0, 1);       // R8 shift left
    // Random
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 16);
      if (op == 14 && ($urandom % 2) == 0) op = int'($urandom % 14);
      do_op(op, int'($urandom % 256), int'($urandom % 256), ($urandom % 10) != 0);
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule